// File: doc/BRIEF.md
# Memory-to-Stream Block Reader

This block replaces a camera-style data source with data fetched from memory. Software (or a fixed build-time setting) gives it a starting word address and a word count. Once started, it issues single-word reads on a memory master port, collects the returned words in a small FIFO, and hands them out on a plain valid/ready stream. The final word of the block is flagged. While the transfer runs, `busy` is high. When the final word leaves the stream port, `done` goes high and stays high until the next accepted start.

The datapath is a pair of loadable counters. An address counter steps up by one word on every read the memory accepts. A word counter steps down toward zero. A three-state machine sequences the transfer. ST_IDLE waits for a start. The "launch" transition goes to ST_FETCH, which issues reads. The "all issued" transition, taken when the last read is accepted, goes to ST_DRAIN. ST_DRAIN waits for the stream to take the final word, and the "finish" transition then returns to ST_IDLE. A read is raised only while the FIFO has a free slot for every read still in flight, so returned words are never lost, whatever the backpressure. When the `USE_FIXED` parameter is set, the registers come out of reset holding built-in values and a transfer starts by itself.

Top module: `mem_stream_dma`

## Requirements
- R1: After reset, `busy`, `done`, `mem_read` and `st_valid` are 0, and the status register reads 0.
- R2: The configuration space decodes `cfg_addr` as follows. 0 is the start word address (low AW bits). 1 is the word count (low LW bits). 2 is control: writing bit0 = 1 requests a start, and the register reads 0. 3 is status, with bit0 = busy and bit1 = done. The values written to offsets 0 and 1 read back unchanged, and `cfg_rdata` is valid in the same cycle as `cfg_addr`.
- R3: A transfer of N words issues exactly N accepted reads (`mem_read` high with `mem_waitreq` low), at addresses base, base+1, …, base+N−1 (modulo 2^AW).
- R4: While `mem_read` is high and `mem_waitreq` is high, `mem_read` stays high and `mem_addr` stays unchanged in the next cycle.
- R5: Accepted reads minus words delivered on the stream never exceeds FIFO_DEPTH. Every returned word appears on the stream exactly once, in order, under any `st_ready` pattern.
- R6: `st_last` is 1 on the final word of a block and 0 on all other words.
- R7: `busy` is high from the cycle after the start request is registered until the final word is taken. `done` then rises, stays set while idle, and clears on the next accepted start of a non-empty block. `done` and `busy` are never both 1.
- R8: A start request while `busy` is high is ignored. The running block completes with its original length, and no further reads follow it.
- R9: A start with a word count of 0 sets `done` one cycle after the request is registered, with no read and no stream word.
- R10: With `USE_FIXED` = 1, the block starts by itself after reset from FIXED_ADDR and FIXED_LEN, with no configuration access.
- R11: While `st_valid` is high and `st_ready` is low, `st_valid`, `st_data` and `st_last` hold in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_write | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| mem_addr | output | AW | Memory word address |
| mem_read | output | 1 | Memory read request |
| mem_waitreq | input | 1 | Memory stall; request must be held |
| mem_rdata | input | DW | Returned read data |
| mem_rvalid | input | 1 | Returned data valid |
| st_data | output | DW | Stream data |
| st_valid | output | 1 | Stream data valid |
| st_last | output | 1 | Final word of block |
| st_ready | input | 1 | Stream consumer ready |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Block complete, sticky |

## Verification
The hardest situation to reach is the throttle point. There, reads in flight plus words buffered fill the FIFO exactly, while the memory is still stalling a pending request. The bench holds `st_ready` low for many cycles during a ten-word block, and a pseudo-random `mem_waitreq` keeps stalling reads. This drives the block into the point where it must stop asking without dropping data. A second run issues a new start and rewrites the length while the stream is held off. It then confirms that the old block finishes intact and that nothing more is fetched.

// File: rtl/dma_pkg.sv
`timescale 1ns/1ps
package dma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DRAIN = 2'd2
    } dma_state_t;

    localparam logic [1:0] REG_BASE = 2'd0;
    localparam logic [1:0] REG_LEN  = 2'd1;
    localparam logic [1:0] REG_CTRL = 2'd2;
    localparam logic [1:0] REG_STAT = 2'd3;
endpackage

// File: rtl/dma_cfg.sv
`timescale 1ns/1ps
module dma_cfg
    import dma_pkg::*;
#(
    parameter int unsigned AW         = 16,
    parameter int unsigned LW         = 12,
    parameter bit          USE_FIXED  = 1'b0,
    parameter int unsigned FIXED_ADDR = 0,
    parameter int unsigned FIXED_LEN  = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    addr,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata,
    input  logic          busy,
    input  logic          done,
    output logic [AW-1:0] base_addr,
    output logic [LW-1:0] blk_len,
    output logic          start_pulse
);
    logic [AW-1:0] base_q;
    logic [LW-1:0] len_q;
    logic          start_q;
    logic          auto_go;
    logic          wdata_unused;

    assign wdata_unused = ^wdata;

    generate
        if (USE_FIXED) begin : g_auto
            logic fired_q;
            always_ff @(posedge clk) begin
                if (!rst_n) fired_q <= 1'b0;
                else        fired_q <= 1'b1;
            end
            assign auto_go = !fired_q && rst_n;
        end else begin : g_manual
            assign auto_go = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= USE_FIXED ? AW'(FIXED_ADDR) : '0;
            len_q   <= USE_FIXED ? LW'(FIXED_LEN)  : '0;
            start_q <= 1'b0;
        end else begin
            start_q <= auto_go || (wr_en && addr == REG_CTRL && wdata[0]);
            if (wr_en && addr == REG_BASE) base_q <= wdata[AW-1:0];
            if (wr_en && addr == REG_LEN)  len_q  <= wdata[LW-1:0];
        end
    end

    always_comb begin
        unique case (addr)
            REG_BASE: rdata = 32'(base_q);
            REG_LEN:  rdata = 32'(len_q);
            REG_CTRL: rdata = 32'd0;
            REG_STAT: rdata = {30'd0, done, busy};
            default:  rdata = 32'd0;
        endcase
    end

    assign base_addr   = base_q;
    assign blk_len     = len_q;
    assign start_pulse = start_q;
endmodule

// File: rtl/dma_fifo.sv
`timescale 1ns/1ps
module dma_fifo #(
    parameter int unsigned DW    = 32,
    parameter int unsigned DEPTH = 4,
    parameter int unsigned CW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          push_last,
    output logic [DW-1:0] st_data,
    output logic          st_last,
    output logic          st_valid,
    input  logic          st_ready,
    output logic [CW-1:0] count
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW:0]   store [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          pop;

    assign pop = st_valid && st_ready;

    always_ff @(posedge clk) begin
        if (push) store[wp_q] <= {push_last, push_data};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            if (pop)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            unique case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign st_valid            = (cnt_q != '0);
    assign {st_last, st_data}  = store[rp_q];
    assign count               = cnt_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (32'(cnt_q) < DEPTH)); // R5

    AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ready) |=> (st_valid && $stable(st_data) && $stable(st_last))); // R11
endmodule

// File: rtl/dma_ctrl.sv
`timescale 1ns/1ps
module dma_ctrl
    import dma_pkg::*;
#(
    parameter int unsigned AW    = 16,
    parameter int unsigned LW    = 12,
    parameter int unsigned DEPTH = 4,
    parameter int unsigned CW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] base_addr,
    input  logic [LW-1:0] blk_len,
    output logic [AW-1:0] mem_addr,
    output logic          mem_read,
    input  logic          mem_waitreq,
    input  logic          mem_rvalid,
    input  logic [CW-1:0] fifo_count,
    input  logic          pop_last,
    output logic          push,
    output logic          push_last,
    output logic          busy,
    output logic          done
);
    dma_state_t    state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [LW-1:0] issue_q;
    logic [LW-1:0] rx_q;
    logic [CW-1:0] infl_q;
    logic          done_q;
    logic          accept;
    logic          launch;
    logic          room;

    assign accept = mem_read && !mem_waitreq;
    assign launch = start && (state_q == ST_IDLE);
    assign room   = ({1'b0, fifo_count} + {1'b0, infl_q}) < (CW+1)'(DEPTH);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        mem_read = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start && blk_len != '0) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                mem_read = room;
                if (room && !mem_waitreq && issue_q == LW'(1)) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (pop_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            issue_q <= '0;
            rx_q    <= '0;
            infl_q  <= '0;
            done_q  <= 1'b0;
        end else if (launch) begin
            addr_q  <= base_addr;
            issue_q <= blk_len;
            rx_q    <= blk_len;
            infl_q  <= '0;
            done_q  <= (blk_len == '0);
        end else begin
            if (accept) begin
                addr_q  <= addr_q + 1'b1;
                issue_q <= issue_q - 1'b1;
            end
            if (push) rx_q <= rx_q - 1'b1;
            unique case ({accept, mem_rvalid})
                2'b10:   infl_q <= infl_q + 1'b1;
                2'b01:   infl_q <= infl_q - 1'b1;
                default: infl_q <= infl_q;
            endcase
            if (pop_last && state_q == ST_DRAIN) done_q <= 1'b1;
        end
    end

    assign mem_addr  = addr_q;
    assign push      = mem_rvalid && (rx_q != '0);
    assign push_last = (rx_q == LW'(1));
    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_read && mem_waitreq) |=> (mem_read && $stable(mem_addr))); // R4

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && issue_q != LW'(1)) |=> (mem_addr == $past(mem_addr) + 1'b1)); // R3

    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R7

    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && blk_len == '0) |=> (done && !busy && !mem_read)); // R9
endmodule

// File: rtl/mem_stream_dma.sv
`timescale 1ns/1ps
module mem_stream_dma #(
    parameter int unsigned AW         = 16,
    parameter int unsigned DW         = 32,
    parameter int unsigned LW         = 12,
    parameter int unsigned FIFO_DEPTH = 4,
    parameter bit          USE_FIXED  = 1'b0,
    parameter int unsigned FIXED_ADDR = 0,
    parameter int unsigned FIXED_LEN  = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_write,
    input  logic [1:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_read,
    input  logic          mem_waitreq,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_rvalid,
    output logic [DW-1:0] st_data,
    output logic          st_valid,
    output logic          st_last,
    input  logic          st_ready,
    output logic          busy,
    output logic          done
);
    localparam int unsigned CW = $clog2(FIFO_DEPTH + 1);

    logic [AW-1:0] base_addr;
    logic [LW-1:0] blk_len;
    logic          start_pulse;
    logic [CW-1:0] fifo_count;
    logic          push, push_last;
    logic          pop_last;

    assign pop_last = st_valid && st_ready && st_last;

    dma_cfg #(
        .AW(AW), .LW(LW), .USE_FIXED(USE_FIXED),
        .FIXED_ADDR(FIXED_ADDR), .FIXED_LEN(FIXED_LEN)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_write), .addr(cfg_addr), .wdata(cfg_wdata), .rdata(cfg_rdata),
        .busy(busy), .done(done),
        .base_addr(base_addr), .blk_len(blk_len), .start_pulse(start_pulse)
    );

    dma_ctrl #(
        .AW(AW), .LW(LW), .DEPTH(FIFO_DEPTH), .CW(CW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .start(start_pulse), .base_addr(base_addr), .blk_len(blk_len),
        .mem_addr(mem_addr), .mem_read(mem_read), .mem_waitreq(mem_waitreq),
        .mem_rvalid(mem_rvalid), .fifo_count(fifo_count), .pop_last(pop_last),
        .push(push), .push_last(push_last), .busy(busy), .done(done)
    );

    dma_fifo #(
        .DW(DW), .DEPTH(FIFO_DEPTH), .CW(CW)
    ) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_data(mem_rdata), .push_last(push_last),
        .st_data(st_data), .st_last(st_last), .st_valid(st_valid),
        .st_ready(st_ready), .count(fifo_count)
    );
endmodule

// File: tb/tb_mem_stream_dma.sv
`timescale 1ns/1ps
module tb_mem_stream_dma;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_write = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [31:0] cfg_rdata;
    logic [15:0] mem_addr;
    logic        mem_read;
    logic        mem_waitreq = 1'b0;
    logic [31:0] mem_rdata;
    logic        mem_rvalid;
    logic [31:0] st_data;
    logic        st_valid, st_last;
    logic        st_ready = 1'b1;
    logic        busy, done;

    always #2 clk = ~clk;

    mem_stream_dma dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_write(cfg_write), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mem_addr(mem_addr), .mem_read(mem_read), .mem_waitreq(mem_waitreq),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .st_data(st_data), .st_valid(st_valid), .st_last(st_last), .st_ready(st_ready),
        .busy(busy), .done(done)
    );

    // second instance: built-in setup, free-running memory and consumer
    logic [31:0] fx_rdata_unused;
    logic [15:0] fx_addr;
    logic        fx_read, fx_rv;
    logic [15:0] fx_ra;
    logic [31:0] fx_data;
    logic        fx_valid, fx_last, fx_busy, fx_done;

    mem_stream_dma #(.USE_FIXED(1'b1), .FIXED_ADDR(16'h0040), .FIXED_LEN(3)) dut_fx (
        .clk(clk), .rst_n(rst_n),
        .cfg_write(1'b0), .cfg_addr(2'd0), .cfg_wdata(32'd0), .cfg_rdata(fx_rdata_unused),
        .mem_addr(fx_addr), .mem_read(fx_read), .mem_waitreq(1'b0),
        .mem_rdata({~fx_ra, fx_ra}), .mem_rvalid(fx_rv),
        .st_data(fx_data), .st_valid(fx_valid), .st_last(fx_last), .st_ready(1'b1),
        .busy(fx_busy), .done(fx_done)
    );

    function automatic logic [31:0] word_at(input logic [15:0] a);
        return {~a, a};
    endfunction

    // memory model: two-cycle read latency
    logic        p1_v, p2_v;
    logic [15:0] p1_a, p2_a;
    assign mem_rvalid = p2_v;
    assign mem_rdata  = word_at(p2_a);

    always @(posedge clk) begin
        if (!rst_n) begin
            p1_v <= 1'b0; p2_v <= 1'b0; p1_a <= '0; p2_a <= '0;
            fx_rv <= 1'b0; fx_ra <= '0;
        end else begin
            p1_v <= mem_read && !mem_waitreq;
            p1_a <= mem_addr;
            p2_v <= p1_v;
            p2_a <= p1_a;
            fx_rv <= fx_read;
            fx_ra <= fx_addr;
        end
    end

    // stall and backpressure patterns
    logic [15:0] lfsr = 16'hACE1;
    logic        wait_en = 1'b0;
    int          rdy_mode = 0;
    always @(negedge clk) begin
        lfsr        <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_waitreq <= wait_en & lfsr[0];
        case (rdy_mode)
            0:       st_ready <= 1'b1;
            1:       st_ready <= lfsr[3] | lfsr[7];
            default: st_ready <= 1'b0;
        endcase
    end

    // monitors
    logic [15:0] acc_addr [256];
    logic [31:0] rcv_data [256];
    logic        rcv_last [256];
    int acc_n = 0, rcv_n = 0, hold_err = 0, sh_err = 0, occ_err = 0;
    logic        prev_hold = 1'b0, prev_sh = 1'b0;
    logic [15:0] prev_addr = '0;
    logic [31:0] prev_data = '0;
    int fx_n = 0, fx_bad = 0;

    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_read && !mem_waitreq) begin
                if (acc_n < 256) acc_addr[acc_n] <= mem_addr;
                acc_n <= acc_n + 1;
            end
            if (st_valid && st_ready) begin
                if (rcv_n < 256) begin
                    rcv_data[rcv_n] <= st_data;
                    rcv_last[rcv_n] <= st_last;
                end
                rcv_n <= rcv_n + 1;
            end
            if (prev_hold && !(mem_read && mem_addr == prev_addr)) hold_err <= hold_err + 1;
            if (prev_sh && !(st_valid && st_data == prev_data)) sh_err <= sh_err + 1;
            if (acc_n - rcv_n > DEPTH) occ_err <= occ_err + 1;
            prev_hold <= mem_read && mem_waitreq;
            prev_addr <= mem_addr;
            prev_sh   <= st_valid && !st_ready;
            prev_data <= st_data;
            if (fx_valid) begin
                if (fx_data != word_at(16'h0040 + 16'(fx_n)) || fx_last != (fx_n == 2)) fx_bad <= fx_bad + 1;
                fx_n <= fx_n + 1;
            end
        end
    end

    int checks = 0, fails = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_write = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_write = 1'b0;
    endtask

    task automatic cfg_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    task automatic verify_block(input logic [15:0] base, input int len, input int a0, input int r0);
        int bad_a = 0, bad_d = 0, bad_l = 0;
        logic [31:0] st;
        chk(acc_n - a0 == len, "R3 read count", 32'(acc_n - a0), 32'(len));
        for (int i = 0; i < len; i++) begin
            if (acc_addr[a0 + i] != base + 16'(i)) bad_a++;
            if (rcv_data[r0 + i] != word_at(base + 16'(i))) bad_d++;
            if (rcv_last[r0 + i] != (i == len - 1)) bad_l++;
        end
        chk(bad_a == 0, "R3 address sequence", 32'(bad_a), 0);
        chk(rcv_n - r0 == len, "R5 stream word count", 32'(rcv_n - r0), 32'(len));
        chk(bad_d == 0, "R5 stream data order", 32'(bad_d), 0);
        chk(bad_l == 0, "R6 last flag placement", 32'(bad_l), 0);
        chk(hold_err == 0, "R4 request held under stall", 32'(hold_err), 0);
        chk(sh_err == 0, "R11 stream held under backpressure", 32'(sh_err), 0);
        chk(occ_err == 0, "R5 outstanding within depth", 32'(occ_err), 0);
        cfg_rd(2'd3, st);
        chk(st == 32'h2, "R7 status done after block", st, 32'h2);
    endtask

    task automatic t_reset();
        logic [31:0] st;
        cfg_rd(2'd3, st);
        chk(st == 0, "R1 status after reset", st, 0);
        chk(!busy && !done, "R1 busy/done after reset", {30'd0, done, busy}, 0);
        chk(!mem_read && !st_valid, "R1 read/valid after reset", {30'd0, st_valid, mem_read}, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        cfg_wr(2'd0, 32'h0000_1234);
        cfg_wr(2'd1, 32'h0000_0007);
        cfg_rd(2'd0, d);
        chk(d == 32'h1234, "R2 base readback", d, 32'h1234);
        cfg_rd(2'd1, d);
        chk(d == 32'h7, "R2 length readback", d, 32'h7);
        cfg_rd(2'd2, d);
        chk(d == 0, "R2 control reads zero", d, 0);
    endtask

    task automatic t_xfer(input logic [15:0] base, input int len, input bit we, input int rm, input string tag);
        int a0 = acc_n, r0 = rcv_n;
        wait_en = we; rdy_mode = rm;
        cfg_wr(2'd0, 32'(base));
        cfg_wr(2'd1, 32'(len));
        cfg_wr(2'd2, 32'h1);
        @(negedge clk);
        chk(busy && !done, {"R7 busy after start ", tag}, {30'd0, done, busy}, 32'h1);
        wait_idle();
        verify_block(base, len, a0, r0);
        wait_en = 1'b0; rdy_mode = 0;
    endtask

    task automatic t_throttle();
        int a0 = acc_n, r0 = rcv_n;
        wait_en = 1'b1; rdy_mode = 2;
        cfg_wr(2'd0, 32'h0000_5000);
        cfg_wr(2'd1, 32'd10);
        cfg_wr(2'd2, 32'h1);
        repeat (40) @(negedge clk);
        chk(acc_n - a0 == DEPTH, "R5 reads stop at depth while stalled", 32'(acc_n - a0), DEPTH);
        chk(rcv_n == r0 && st_valid, "R11 nothing taken while not ready", 32'(rcv_n - r0), 0);
        rdy_mode = 1;
        wait_idle();
        verify_block(16'h5000, 10, a0, r0);
        wait_en = 1'b0; rdy_mode = 0;
    endtask

    task automatic t_restart_ignored();
        int a0 = acc_n, r0 = rcv_n, a_end;
        logic [31:0] d;
        rdy_mode = 2;
        cfg_wr(2'd0, 32'h0000_0300);
        cfg_wr(2'd1, 32'd6);
        cfg_wr(2'd2, 32'h1);
        repeat (3) @(negedge clk);
        cfg_wr(2'd1, 32'd3);
        cfg_wr(2'd2, 32'h1);
        repeat (20) @(negedge clk);
        chk(busy, "R8 still busy after ignored start", {31'd0, busy}, 1);
        rdy_mode = 1;
        wait_idle();
        verify_block(16'h0300, 6, a0, r0);
        a_end = acc_n;
        repeat (20) @(negedge clk);
        chk(acc_n == a_end && !busy, "R8 no reads after ignored start", 32'(acc_n - a_end), 0);
        cfg_rd(2'd1, d);
        chk(d == 3, "R2 length register took new value", d, 3);
        cfg_rd(2'd3, d);
        chk(d == 32'h2, "R7 done sticky while idle", d, 32'h2);
        rdy_mode = 0;
    endtask

    task automatic t_zero_len();
        int a0 = acc_n, r0 = rcv_n;
        logic [31:0] d;
        cfg_wr(2'd1, 32'd0);
        cfg_wr(2'd2, 32'h1);
        @(negedge clk);
        chk(done && !busy, "R9 done at once for zero length", {30'd0, done, busy}, 32'h2);
        repeat (10) @(negedge clk);
        chk(acc_n == a0 && rcv_n == r0, "R9 no reads or words for zero length",
            32'(acc_n - a0 + rcv_n - r0), 0);
        cfg_rd(2'd3, d);
        chk(d == 32'h2, "R9 status after zero length", d, 32'h2);
    endtask

    task automatic t_fixed();
        chk(fx_n == 3 && fx_bad == 0, "R10 built-in block delivered", 32'(fx_n), 3);
        chk(fx_done && !fx_busy, "R10 built-in block done", {30'd0, fx_done, fx_busy}, 32'h2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_xfer(16'h0100, 5, 1'b0, 0, "plain");
        // done clears on new start: checked inside t_xfer busy/done pair
        t_xfer(16'h2000, 20, 1'b1, 1, "stalls");
        t_xfer(16'hFFFE, 4, 1'b1, 0, "wrap");
        t_throttle();
        t_restart_ignored();
        t_zero_len();
        t_fixed();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule